// File: doc/BRIEF.md
# Register-File ALU Datapath with Data Memory

This block is the execution core of a small processor. It holds four general registers with two read ports and one write port, an arithmetic-logic unit that reports sign, zero, carry and signed-overflow status, and a data memory of 2^n words of n bits. An external controller drives all of the control inputs each cycle: the two read selects, the write select and write enable, a 5-bit function code, a memory write enable and a write-back source select.

The ALU takes its operands from the two register read ports. Memory is reached only through the registers. Read port A supplies the memory address, and read port B supplies the store data. A source select then chooses whether the ALU result or the memory word is written back into the register file. Every operation finishes in one clock cycle. Instruction fetch and decoding stay outside the block.

Top module: `dp_core`

## Requirements
- R1: An active-low asynchronous reset clears all four registers to zero. The reset does not clear the data memory, so its contents survive a reset.
- R2: `rd_a_o` shows the register selected by `aa_i` and `rd_b_o` shows the register selected by `ba_i`. Both ports are combinational and follow a change of select without waiting for a clock edge.
- R3: When `wr_i`=1, the register selected by `da_i` takes the write-back value at the rising clock edge. When `wr_i`=0, no register changes.
- R4: The arithmetic codes are 00001 (A+1), 00010 (A+B), 00101 (A−B, computed as A+~B+1) and 00110 (A−1, computed as A plus all ones). For these codes, `c_o` is the carry out of that n-bit addition.
- R5: For the arithmetic codes, `v_o` is 1 exactly when both addends have the same sign bit and the result's sign bit differs from it.
- R6: For every code, `n_o` equals the most significant bit of `alu_f_o`, and `z_o` is 1 exactly when `alu_f_o` is all zeros.
- R7: The non-arithmetic codes are 00000 (pass A), 01000 (A AND B), 01010 (A OR B), 01100 (A XOR B), 01110 (NOT A), 10000 (pass B), 10100 (B shifted right by one, with a zero filled in) and 11000 (B shifted left by one, with a zero filled in). Any other code passes A. For all of these codes, `c_o`=0 and `v_o`=0.
- R8: The memory address is `rd_a_o` and the store data is `rd_b_o`. When `mw_i`=1, the word is written at the rising edge. When `mw_i`=0, memory is left unchanged. A memory read is combinational from the address.
- R9: The write-back value is the ALU result when `md_i`=0 and the memory word at address `rd_a_o` when `md_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| aa_i | input | 2 | Select for read port A |
| ba_i | input | 2 | Select for read port B |
| da_i | input | 2 | Select for the write port |
| wr_i | input | 1 | Register write enable |
| fs_i | input | 5 | ALU function code |
| mw_i | input | 1 | Memory write enable |
| md_i | input | 1 | Write-back source: 0 selects the ALU, 1 selects memory |
| rd_a_o | output | DATA_W | Read port A data |
| rd_b_o | output | DATA_W | Read port B data |
| alu_f_o | output | DATA_W | ALU result |
| v_o | output | 1 | Signed overflow |
| c_o | output | 1 | Carry out |
| n_o | output | 1 | Result negative |
| z_o | output | 1 | Result zero |

## Verification
The register and memory properties assume that every control input is a known value at each sampled edge. They also assume that reads and writes may target the same location in one cycle, in which case the register file or memory returns the new value only on the following cycle. The memory store property assumes the address register keeps its value across the store cycle, so it only applies when the address does not move. The bench drives every control from time zero and changes inputs only just after a rising edge. It loads registers only through the ALU and write-back path, so the registers never hold undefined values.

// File: rtl/dp_pkg.sv
package dp_pkg;
  typedef enum logic [4:0] {
    FS_PASS_A = 5'b00000,
    FS_INC    = 5'b00001,
    FS_ADD    = 5'b00010,
    FS_SUB    = 5'b00101,
    FS_DEC    = 5'b00110,
    FS_AND    = 5'b01000,
    FS_OR     = 5'b01010,
    FS_XOR    = 5'b01100,
    FS_NOT    = 5'b01110,
    FS_PASS_B = 5'b10000,
    FS_SHR    = 5'b10100,
    FS_SHL    = 5'b11000
  } fs_e;

  typedef struct packed {
    logic v;
    logic c;
    logic n;
    logic z;
  } flags_t;
endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int W  = 8,
  parameter int AW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i,
  input  logic [AW-1:0] ra_a_i,
  input  logic [AW-1:0] ra_b_i,
  output logic [W-1:0]  rd_a_o,
  output logic [W-1:0]  rd_b_o
);
  localparam int N = 1 << AW;

  logic [N-1:0] ld;
  logic [W-1:0] q [N];

  // write decoder gated by enable
  always_comb ld = we_i ? ({{(N-1){1'b0}}, 1'b1} << wa_i) : '0;

  for (genvar g = 0; g < N; g++) begin : g_reg
    logic [W-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   r_q <= '0;
      else if (ld[g]) r_q <= wd_i;
    end
    assign q[g] = r_q;
  end

  assign rd_a_o = q[ra_a_i];
  assign rd_b_o = q[ra_b_i];
endmodule

// File: rtl/dp_alu.sv
module dp_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [4:0]     fs_i,
  output logic [W-1:0]   f_o,
  output dp_pkg::flags_t flg_o
);
  import dp_pkg::*;

  logic [W-1:0] opb;
  logic         cin;
  logic         arith;
  logic [W:0]   sum;

  // operand select for the shared adder
  always_comb begin
    opb   = '0;
    cin   = 1'b0;
    arith = 1'b1;
    case (fs_i)
      FS_INC:  cin = 1'b1;
      FS_ADD:  opb = b_i;
      FS_SUB:  begin opb = ~b_i; cin = 1'b1; end
      FS_DEC:  opb = '1;
      default: arith = 1'b0;
    endcase
  end

  assign sum = {1'b0, a_i} + {1'b0, opb} + {{W{1'b0}}, cin};

  always_comb begin
    case (fs_i)
      FS_AND:    f_o = a_i & b_i;
      FS_OR:     f_o = a_i | b_i;
      FS_XOR:    f_o = a_i ^ b_i;
      FS_NOT:    f_o = ~a_i;
      FS_PASS_B: f_o = b_i;
      FS_SHR:    f_o = b_i >> 1;
      FS_SHL:    f_o = b_i << 1;
      default:   f_o = arith ? sum[W-1:0] : a_i;
    endcase
  end

  assign flg_o.c = arith & sum[W];
  assign flg_o.v = arith & (a_i[W-1] == opb[W-1]) & (sum[W-1] != a_i[W-1]);
  assign flg_o.n = f_o[W-1];
  assign flg_o.z = (f_o == '0);
endmodule

// File: rtl/dp_ram.sv
module dp_ram #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         we_i,
  input  logic [W-1:0] addr_i,
  input  logic [W-1:0] wd_i,
  output logic [W-1:0] rd_o
);
  localparam int DEPTH = 1 << W;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wd_i;
  end

  assign rd_o = mem[addr_i];
endmodule

// File: rtl/dp_core.sv
module dp_core #(
  parameter int DATA_W = 8,
  parameter int RA_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RA_W-1:0]   aa_i,
  input  logic [RA_W-1:0]   ba_i,
  input  logic [RA_W-1:0]   da_i,
  input  logic              wr_i,
  input  logic [4:0]        fs_i,
  input  logic              mw_i,
  input  logic              md_i,
  output logic [DATA_W-1:0] rd_a_o,
  output logic [DATA_W-1:0] rd_b_o,
  output logic [DATA_W-1:0] alu_f_o,
  output logic              v_o,
  output logic              c_o,
  output logic              n_o,
  output logic              z_o
);
  dp_pkg::flags_t    flg;
  logic [DATA_W-1:0] ram_q;
  logic [DATA_W-1:0] wb_d;

  dp_regfile #(.W(DATA_W), .AW(RA_W)) i_regfile (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_i),
    .wa_i   (da_i),
    .wd_i   (wb_d),
    .ra_a_i (aa_i),
    .ra_b_i (ba_i),
    .rd_a_o (rd_a_o),
    .rd_b_o (rd_b_o)
  );

  dp_alu #(.W(DATA_W)) i_alu (
    .a_i   (rd_a_o),
    .b_i   (rd_b_o),
    .fs_i  (fs_i),
    .f_o   (alu_f_o),
    .flg_o (flg)
  );

  dp_ram #(.W(DATA_W)) i_ram (
    .clk_i  (clk_i),
    .we_i   (mw_i),
    .addr_i (rd_a_o),
    .wd_i   (rd_b_o),
    .rd_o   (ram_q)
  );

  assign wb_d = md_i ? ram_q : alu_f_o;

  assign v_o = flg.v;
  assign c_o = flg.c;
  assign n_o = flg.n;
  assign z_o = flg.z;
endmodule

// File: rtl/dp_core_chk.sv
module dp_core_chk #(
  parameter int W  = 8,
  parameter int AW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] aa_i,
  input logic [AW-1:0] da_i,
  input logic          wr_i,
  input logic [4:0]    fs_i,
  input logic          mw_i,
  input logic          md_i,
  input logic [W-1:0]  rd_a_o,
  input logic [W-1:0]  rd_b_o,
  input logic [W-1:0]  alu_f_o,
  input logic          v_o,
  input logic          c_o,
  input logic [W-1:0]  wb_d,
  input logic [W-1:0]  ram_q
);
  import dp_pkg::*;

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  a_r3_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(wr_i) && aa_i == $past(da_i)) |-> rd_a_o == $past(wb_d));

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(wr_i) && aa_i == $past(aa_i)) |-> rd_a_o == $past(rd_a_o));

  a_r9_ram_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(wr_i && md_i && !mw_i) && aa_i == $past(da_i)) |-> rd_a_o == $past(ram_q));

  a_r9_alu_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(wr_i && !md_i) && aa_i == $past(da_i)) |-> rd_a_o == $past(alu_f_o));

  a_r8_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(mw_i) && rd_a_o == $past(rd_a_o)) |-> ram_q == $past(rd_b_o));

  a_r7_no_arith_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_i inside {FS_PASS_A, FS_AND, FS_OR, FS_XOR, FS_NOT, FS_PASS_B, FS_SHR, FS_SHL})
      |-> (!c_o && !v_o));

  a_r5_add_same_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_i == FS_ADD && v_o) |-> rd_a_o[W-1] == rd_b_o[W-1]);
endmodule

bind dp_core dp_core_chk #(.W(DATA_W), .AW(RA_W)) i_dp_core_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .aa_i    (aa_i),
  .da_i    (da_i),
  .wr_i    (wr_i),
  .fs_i    (fs_i),
  .mw_i    (mw_i),
  .md_i    (md_i),
  .rd_a_o  (rd_a_o),
  .rd_b_o  (rd_b_o),
  .alu_f_o (alu_f_o),
  .v_o     (v_o),
  .c_o     (c_o),
  .wb_d    (wb_d),
  .ram_q   (ram_q)
);

// File: tb/test_dp_core.sv
module test_dp_core;
  localparam int W = 8;

  localparam logic [4:0] C_PASS_A = 5'b00000, C_INC = 5'b00001, C_ADD = 5'b00010,
                         C_SUB = 5'b00101, C_DEC = 5'b00110, C_AND = 5'b01000,
                         C_OR = 5'b01010, C_XOR = 5'b01100, C_NOT = 5'b01110,
                         C_PASS_B = 5'b10000, C_SHR = 5'b10100, C_SHL = 5'b11000;

  typedef struct packed {
    logic [4:0]   fs;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] f;
    logic [3:0]   vcnz;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{C_ADD,    8'h7F, 8'h01, 8'h80, 4'b1010},
    '{C_ADD,    8'hFF, 8'h01, 8'h00, 4'b0101},
    '{C_SUB,    8'h05, 8'h05, 8'h00, 4'b0101},
    '{C_SUB,    8'h03, 8'h05, 8'hFE, 4'b0010},
    '{C_SUB,    8'h80, 8'h01, 8'h7F, 4'b1100},
    '{C_INC,    8'hFF, 8'h00, 8'h00, 4'b0101},
    '{C_INC,    8'h7F, 8'h00, 8'h80, 4'b1010},
    '{C_DEC,    8'h00, 8'h00, 8'hFF, 4'b0010},
    '{C_DEC,    8'h80, 8'h00, 8'h7F, 4'b1100},
    '{C_AND,    8'hF0, 8'h3C, 8'h30, 4'b0000},
    '{C_OR,     8'hF0, 8'h0C, 8'hFC, 4'b0010},
    '{C_XOR,    8'hAA, 8'hAA, 8'h00, 4'b0001},
    '{C_NOT,    8'h0F, 8'h00, 8'hF0, 4'b0010},
    '{C_PASS_B, 8'h00, 8'h5A, 8'h5A, 4'b0000},
    '{C_SHR,    8'h00, 8'h81, 8'h40, 4'b0000},
    '{C_SHL,    8'h00, 8'h81, 8'h02, 4'b0000},
    '{C_PASS_A, 8'h00, 8'h00, 8'h00, 4'b0001},
    '{5'b11111, 8'h33, 8'h00, 8'h33, 4'b0000}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   aa = '0, ba = '0, da = '0;
  logic         wr = 1'b0, mw = 1'b0, md = 1'b0;
  logic [4:0]   fs = '0;
  logic [W-1:0] rd_a, rd_b, alu_f;
  logic         v, c, n, z;
  int           n_chk = 0;
  int           n_err = 0;
  bit           done = 1'b0;

  always #2 clk = ~clk;

  dp_core #(.DATA_W(W), .RA_W(2)) i_dp_core (
    .clk_i(clk), .rst_ni(rst_n), .aa_i(aa), .ba_i(ba), .da_i(da), .wr_i(wr),
    .fs_i(fs), .mw_i(mw), .md_i(md), .rd_a_o(rd_a), .rd_b_o(rd_b),
    .alu_f_o(alu_f), .v_o(v), .c_o(c), .n_o(n), .z_o(z)
  );

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    wr = 1'b0; mw = 1'b0; md = 1'b0;
  endtask

  task automatic wop(logic [4:0] f, logic [1:0] a, logic [1:0] b, logic [1:0] d);
    fs = f; aa = a; ba = b; da = d; wr = 1'b1; md = 1'b0;
    tick();
  endtask

  // build a value in register d through the ALU only
  task automatic set_reg(logic [1:0] d, logic [W-1:0] val);
    wop(C_XOR, d, d, d);
    for (int i = W - 1; i >= 0; i--) begin
      wop(C_SHL, d, d, d);
      if (val[i]) wop(C_INC, d, d, d);
    end
  endtask

  task automatic peek_a(string tag, logic [1:0] r, logic [W-1:0] exp);
    aa = r; #1;
    check(tag, rd_a, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #11 rst_n = 1'b1;
    tick();

    // R1 reset state, R2 both read ports
    for (int r = 0; r < 4; r++) begin
      aa = 2'(r); ba = 2'(r); #1;
      check("R1 reg after reset", rd_a, '0);
      check("R2 port B after reset", rd_b, '0);
    end

    // table: R4 R5 R6 R7
    for (int k = 0; k < NV; k++) begin
      set_reg(2'd1, VECS[k].a);
      set_reg(2'd2, VECS[k].b);
      fs = VECS[k].fs; aa = 2'd1; ba = 2'd2; #1;
      check((k < 9) ? "R4 result" : "R7 result", alu_f, VECS[k].f);
      check("R5 overflow", W'(v), W'(VECS[k].vcnz[3]));
      check((k < 9) ? "R4 carry" : "R7 carry", W'(c), W'(VECS[k].vcnz[2]));
      check("R6 negative", W'(n), W'(VECS[k].vcnz[1]));
      check("R6 zero", W'(z), W'(VECS[k].vcnz[0]));
    end

    // R2 independent combinational ports
    set_reg(2'd1, 8'h3C);
    set_reg(2'd2, 8'hA5);
    aa = 2'd2; ba = 2'd1; #1;
    check("R2 port A", rd_a, 8'hA5);
    check("R2 port B", rd_b, 8'h3C);

    // R3 write enable low leaves registers
    fs = C_PASS_B; aa = 2'd1; ba = 2'd2; da = 2'd1; wr = 1'b0;
    tick();
    peek_a("R3 no write when wr low", 2'd1, 8'h3C);
    fs = C_PASS_B; aa = 2'd1; ba = 2'd2; da = 2'd1; wr = 1'b1;
    tick();
    peek_a("R3 write when wr high", 2'd1, 8'hA5);

    // R8 store, R9 load from memory
    set_reg(2'd1, 8'h10);
    set_reg(2'd2, 8'hC3);
    aa = 2'd1; ba = 2'd2; mw = 1'b1;
    tick();
    aa = 2'd1; da = 2'd3; md = 1'b1; wr = 1'b1;
    tick();
    peek_a("R9 memory write-back", 2'd3, 8'hC3);

    // R8 mw low does not store
    set_reg(2'd2, 8'h77);
    aa = 2'd1; ba = 2'd2; mw = 1'b0;
    tick();
    aa = 2'd1; da = 2'd3; md = 1'b1; wr = 1'b1;
    tick();
    peek_a("R8 no store when mw low", 2'd3, 8'hC3);

    // R9 md low selects ALU
    fs = C_INC; aa = 2'd1; da = 2'd3; md = 1'b0; wr = 1'b1;
    tick();
    peek_a("R9 alu write-back", 2'd3, 8'h11);

    // R1 mid-run reset clears registers, memory kept
    rst_n = 1'b0; #1; rst_n = 1'b1;
    for (int r = 0; r < 4; r++) peek_a("R1 reg cleared by reset", 2'(r), '0);
    set_reg(2'd1, 8'h10);
    aa = 2'd1; da = 2'd3; md = 1'b1; wr = 1'b1;
    tick();
    peek_a("R1 memory kept over reset", 2'd3, 8'hC3);

    finish_run();
  end
endmodule